// File: doc/BRIEF.md
# Gray-Code Counter with Binary Readout

A synchronous up counter whose state register holds a reflected Gray code, so that each counted clock changes exactly one stored bit. Wide counters (sixteen bits and more) built this way never switch many flip-flops in one edge. Downstream decoders also never see a transient false code, because no counted step passes through an intermediate value.

Every state flip-flop shares one clock. The next Gray value is formed from the current one by converting to binary, adding one and converting back. Only the Gray register is clocked. A combinational converter drives a binary copy of the count for users who need ordinary arithmetic. A terminal-count flag marks the last state before the wrap. A parameter selects between two converter structures: a serial XOR chain, or a logarithmic-depth prefix tree. Both give the same results.

Top module: `gcnt_top`

## Requirements
- R1: When `rst` is high at a rising clock edge, the count becomes zero (`gray_q` and `bin_q` all zeros) whatever `cnt_en` is.
- R2: With `rst` low and `cnt_en` high at an edge, `bin_q` becomes its previous value plus one, modulo 2^WIDTH.
- R3: With `rst` low and `cnt_en` low at an edge, `gray_q`, `bin_q` and `at_last` keep their values.
- R4: At all times `gray_q` equals `bin_q ^ (bin_q >> 1)`; equivalently, bit i of `bin_q` is the XOR of `gray_q` bits i through WIDTH-1.
- R5: Every counted step changes exactly one bit of `gray_q`, including the step from the last state to zero.
- R6: `at_last` is high exactly when `bin_q` is all ones, which is when `gray_q` has only its top bit set.
- R7: A counted step from the all-ones binary value yields zero.
- R8: The converter variant (`CONV` = serial chain or prefix tree) changes no output value; WIDTH below 2 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for every state bit |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count this clock when high |
| gray_q | output | WIDTH | Registered count in reflected Gray code |
| bin_q | output | WIDTH | Binary form of the count, decoded from `gray_q` |
| at_last | output | 1 | High while the count is all ones in binary |

## Verification
Two functions can fall in the same cycle in two ways. Reset can arrive together with a counted step, and the wrap can coincide with a hold or a reset while the counter sits at its last state. The bench drives the counter to all ones, holds it there, and then raises reset and enable together. Random runs set enable about three cycles in four and reset about one in sixty-four, so the overlaps recur many times. Each case is judged against a bench model in which reset takes precedence over counting. Counting in turn takes precedence over holding.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

   // Structure of the Gray-to-binary converter.
   typedef enum int {
      CONV_CHAIN  = 0,  // serial XOR from the top bit down, depth WIDTH-1
      CONV_PREFIX = 1   // parallel prefix XOR, depth ceil(log2(WIDTH))
   } conv_e;

   localparam int MIN_WIDTH = 2;

endpackage

// File: rtl/gcnt_g2b.sv
module gcnt_g2b
   import gcnt_pkg::*;
#(
   parameter int    WIDTH = 24,
   parameter conv_e CONV  = CONV_CHAIN
) (
   input  logic [WIDTH-1:0] gray_i,
   output logic [WIDTH-1:0] bin_o
);

   localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;

   generate
      if (CONV == CONV_CHAIN) begin : g_chain
         logic [WIDTH-1:0] acc;
         assign acc[WIDTH-1] = gray_i[WIDTH-1];
         for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_bit
            assign acc[i] = gray_i[i] ^ acc[i+1];
         end
         assign bin_o = acc;
      end else begin : g_prefix
         logic [WIDTH-1:0] lvl [0:LEVELS];
         assign lvl[0] = gray_i;
         for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
            localparam int SPAN = 1 << k;
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
               if (i + SPAN < WIDTH) begin : g_mix
                  assign lvl[k+1][i] = lvl[k][i] ^ lvl[k][i+SPAN];
               end else begin : g_pass
                  assign lvl[k+1][i] = lvl[k][i];
               end
            end
         end
         assign bin_o = lvl[LEVELS];
      end
   endgenerate

endmodule

// File: rtl/gcnt_b2g.sv
module gcnt_b2g #(
   parameter int WIDTH = 24
) (
   input  logic [WIDTH-1:0] bin_i,
   output logic [WIDTH-1:0] gray_o
);

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         if (i == WIDTH - 1) begin : g_top
            assign gray_o[i] = bin_i[i];
         end else begin : g_low
            assign gray_o[i] = bin_i[i] ^ bin_i[i+1];
         end
      end
   endgenerate

endmodule

// File: rtl/gcnt_step.sv
module gcnt_step
   import gcnt_pkg::*;
#(
   parameter int    WIDTH = 24,
   parameter conv_e CONV  = CONV_CHAIN
) (
   input  logic [WIDTH-1:0] gray_i,
   output logic [WIDTH-1:0] bin_o,
   output logic [WIDTH-1:0] gray_next_o,
   output logic             full_o
);

   logic [WIDTH-1:0] cur_bin;
   logic [WIDTH-1:0] inc_bin;

   gcnt_g2b #(.WIDTH(WIDTH), .CONV(CONV)) u_dec (
      .gray_i (gray_i),
      .bin_o  (cur_bin)
   );

   always_comb begin
      inc_bin = cur_bin + WIDTH'(1);
   end

   gcnt_b2g #(.WIDTH(WIDTH)) u_enc (
      .bin_i  (inc_bin),
      .gray_o (gray_next_o)
   );

   assign bin_o  = cur_bin;
   assign full_o = &cur_bin;

endmodule

// File: rtl/gcnt_top.sv
module gcnt_top
   import gcnt_pkg::*;
#(
   parameter int    WIDTH = 24,
   parameter conv_e CONV  = CONV_CHAIN
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cnt_en,
   output logic [WIDTH-1:0] gray_q,
   output logic [WIDTH-1:0] bin_q,
   output logic             at_last
);

   generate
      if (WIDTH < MIN_WIDTH) begin : g_bad_width
         $error("gcnt_top: WIDTH must be at least %0d", MIN_WIDTH);
      end
      if (CONV != CONV_CHAIN && CONV != CONV_PREFIX) begin : g_bad_conv
         $error("gcnt_top: unknown converter variant");
      end
   endgenerate

   logic [WIDTH-1:0] gray_r;
   logic [WIDTH-1:0] gray_nx;

   gcnt_step #(.WIDTH(WIDTH), .CONV(CONV)) u_step (
      .gray_i      (gray_r),
      .bin_o       (bin_q),
      .gray_next_o (gray_nx),
      .full_o      (at_last)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         gray_r <= '0;
      end else if (cnt_en) begin
         gray_r <= gray_nx;
      end
   end

   assign gray_q = gray_r;

endmodule

// File: rtl/gcnt_chk.sv
module gcnt_chk #(
   parameter int WIDTH = 24
) (
   input logic             clk,
   input logic             rst,
   input logic             cnt_en,
   input logic [WIDTH-1:0] gray_q,
   input logic [WIDTH-1:0] bin_q,
   input logic             at_last
);

   localparam logic [WIDTH-1:0] LAST_GRAY = {1'b1, {(WIDTH-1){1'b0}}};

   assert_reset_zero_R1: assert property (@(posedge clk)
      rst |=> (gray_q == '0));

   assert_bin_step_R2: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> (bin_q == $past(bin_q) + WIDTH'(1)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !cnt_en |=> ($stable(gray_q) && $stable(at_last)));

   assert_code_match_R4: assert property (@(posedge clk) disable iff (rst)
      gray_q == (bin_q ^ (bin_q >> 1)));

   assert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
      cnt_en |=> ($countones(gray_q ^ $past(gray_q)) == 1));

   assert_last_code_R6: assert property (@(posedge clk) disable iff (rst)
      at_last |-> (gray_q == LAST_GRAY));

   assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (at_last && cnt_en) |=> (gray_q == '0));

endmodule

bind gcnt_top gcnt_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .cnt_en  (cnt_en),
   .gray_q  (gray_q),
   .bin_q   (bin_q),
   .at_last (at_last)
);

// File: tb/tb_gcnt_top.sv
module tb_gcnt_top;
   import gcnt_pkg::*;

   localparam int W = 10;
   localparam logic [W-1:0] ALL1 = '1;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cnt_en = 1'b0;
   logic [W-1:0] gray_a, bin_a, gray_b, bin_b;
   logic last_a, last_b;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   gcnt_top #(.WIDTH(W), .CONV(CONV_CHAIN)) dut (
      .clk(clk), .rst(rst), .cnt_en(cnt_en),
      .gray_q(gray_a), .bin_q(bin_a), .at_last(last_a));

   gcnt_top #(.WIDTH(W), .CONV(CONV_PREFIX)) dut_pf (
      .clk(clk), .rst(rst), .cnt_en(cnt_en),
      .gray_q(gray_b), .bin_q(bin_b), .at_last(last_b));

   // model state
   logic [W-1:0] m_bin = '0;
   logic [W-1:0] prev_gray = '0;
   bit was_rst = 1, was_cnt = 0, was_wrap = 0;

   function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
      return b ^ (b >> 1);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // One cycle: check outputs after the last edge, then drive the next one.
   task automatic step(input bit r, input bit e);
      @(negedge clk);
      if (was_rst) chk(bin_a == '0 && gray_a == '0, "R1", bin_a, '0);
      else if (was_cnt) chk(bin_a == m_bin, "R2", bin_a, m_bin);
      else chk(bin_a == m_bin, "R3", bin_a, m_bin);
      chk(gray_a == to_gray(m_bin), "R4", gray_a, to_gray(m_bin));
      chk(last_a == (m_bin == ALL1), "R6", W'(last_a), W'(m_bin == ALL1));
      if (was_cnt)
         chk($countones(gray_a ^ prev_gray) == 1, "R5", gray_a, prev_gray);
      if (was_wrap) chk(bin_a == '0, "R7", bin_a, '0);
      chk(gray_b == gray_a && bin_b == bin_a && last_b == last_a, "R8", bin_b, bin_a);
      prev_gray = gray_a;
      rst = r;
      cnt_en = e;
      was_rst = r;
      was_cnt = !r && e;
      was_wrap = !r && e && (m_bin == ALL1);
      if (r) m_bin = '0;
      else if (e) m_bin = m_bin + W'(1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      // R1: reset with enable high in the same cycle
      step(1, 1);
      step(0, 0);
      // R3: hold at zero
      repeat (5) step(0, 0);
      // R2/R5/R7: full cycle plus a little, through the wrap
      repeat ((1 << W) + 20) step(0, 1);
      // back to zero, then climb to all ones and hold there (R6, R3)
      step(1, 0);
      repeat ((1 << W) - 1) step(0, 1);
      repeat (4) step(0, 0);
      // R1 beats wrap: reset and enable together at the last state
      step(1, 1);
      step(0, 0);
      // random mix
      for (int i = 0; i < 20000; i++) begin
         step(($urandom % 64) == 0, ($urandom % 4) != 0);
      end
      step(0, 0);
      done = 1;
      finish_run();
   end

endmodule